// File: doc/BRIEF.md
# Power-Gate Corruptible Register Bank

This block is a bank of flip-flops that all belong to one switchable power domain. It lets a prototype built on a device without real power islands show what switched-off logic looks like. An active-high power-gate enable stands in for the power switch. When that enable rises, a chosen subset of the flops is forced at once to the opposite of its functional reset value. The forced value is deliberately wrong, so that any consumer which reads the domain while it is off sees garbage rather than plausible data.

Each flop keeps its own functional asynchronous control. A per-bit parameter picks whether that control is a clear or a set. The power-gate enable acts as the opposite asynchronous control and wins over the functional one. A percentage parameter fixes how many flops are corruptible. A seed parameter picks which ones they are, by ranking a per-index hash, so a new seed gives a different subset of the same size. The selection is fixed at elaboration and is shown on a mask output.

Because the forcing is asynchronous and has no release edge, the bank also exposes power-sequencing mistakes. One example is a reset pulse that is given entirely while the domain is gated: it leaves the corruptible flops holding wrong values after power returns.

Top module: `pg_corrupt_bank`

## Requirements
- R1: While `rst_n` is low and `pgen` is low, bit i of `q` immediately takes its functional reset value, which is `FUNC_SET[i]` (1 means a functional asynchronous set, 0 means a functional asynchronous clear).
- R2: When `pgen` rises, every bit with `corrupt_mask[i]`=1 immediately takes `~FUNC_SET[i]`, without any clock edge.
- R3: When `pgen` and `rst_n` are active together, corruptible bits show `~FUNC_SET[i]`, so the power-gate enable overrides the functional reset.
- R4: While `pgen` is high, corruptible bits ignore clock edges and `d`.
- R5: Bits with `corrupt_mask[i]`=0 are unaffected by `pgen`: they load `d[i]` on every rising clock edge while `rst_n` is high, and they reset as in R1.
- R6: After `pgen` falls with `rst_n` high, corruptible bits keep `~FUNC_SET[i]` until the next rising clock edge, which then loads `d`.
- R7: Exactly floor(`WIDTH`*`PCT`/100) bits are corruptible. `corrupt_mask[i]`=1 marks bit i as corruptible. The subset depends only on `SEED`, `WIDTH` and `PCT`.
- R8: A reset pulse that starts and ends while `pgen` is high has no effect on corruptible bits: after `pgen` falls they still hold `~FUNC_SET[i]` until the next clock edge.
- R9: With `PCT`=100 every bit is corruptible and `corrupt_mask` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock of the domain |
| rst_n | input | 1 | Functional asynchronous reset, active low |
| pgen | input | 1 | Power-gate enable, active high; high means the domain is off |
| d | input | WIDTH | Functional data into the flops |
| q | output | WIDTH | Flop contents |
| corrupt_mask | output | WIDTH | Elaboration-time mark of corruptible bits |

## Verification
The bench builds two copies of the bank and drives them from one stimulus. The first has 16 bits at 25 percent with mixed set and clear polarities. Four corruptible bits sit among twelve live ones, so forcing, holding and normal loading are all visible in the same word. The second has 8 bits at 100 percent, which reaches the upper limit of the rank selection and makes every bit subject to the power-gate enable. The sequences cover the gate rising and falling and reset overlapping the gate. They also cover a reset pulse hidden inside the gated window, with random data throughout.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  localparam int unsigned PCT_FULL = 100;

  // Integer mixer used to rank bit indices for seeded selection.
  function automatic logic [31:0] mix32(input logic [31:0] seed, input logic [31:0] idx);
    logic [31:0] x;
    x = seed ^ (idx * 32'h9E37_79B9);
    x = x ^ (x >> 16);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    x = x * 32'hC2B2_AE35;
    x = x ^ (x >> 16);
    return x;
  endfunction

endpackage

// File: rtl/pgc_select.sv
module pgc_select #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned PCT   = 25,
  parameter logic [31:0] SEED  = 32'h1234_5678
) (
  output logic [WIDTH-1:0] mask
);
  import pgc_pkg::*;

  localparam int unsigned KEEP = (WIDTH * PCT) / PCT_FULL;

  // A bit is selected when its hash ranks among the KEEP smallest.
  function automatic logic [WIDTH-1:0] build_mask();
    logic [WIDTH-1:0] sel;
    logic [31:0]      ki;
    logic [31:0]      kj;
    int unsigned      rank;
    sel = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      rank = 0;
      ki   = mix32(SEED, 32'(i));
      for (int j = 0; j < int'(WIDTH); j++) begin
        kj = mix32(SEED, 32'(j));
        if ((kj < ki) || ((kj == ki) && (j < i))) rank++;
      end
      sel[i] = (rank < KEEP);
    end
    return sel;
  endfunction

  localparam logic [WIDTH-1:0] SEL_MASK = build_mask();

  assign mask = SEL_MASK;

endmodule

// File: rtl/pgc_cell.sv
module pgc_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgen,
  input  logic sel,
  input  logic d,
  output logic q
);

  logic force_on;
  logic q_nxt;
  logic q_r;

  always_comb begin
    force_on = pgen & sel;
    q_nxt    = d;
  end

  // Power-gate forcing outranks the functional asynchronous control.
  always_ff @(posedge clk or negedge rst_n or posedge force_on) begin
    if (force_on) begin
      q_r <= ~RST_VAL;
    end else if (!rst_n) begin
      q_r <= RST_VAL;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  p_reset_value_r1: assert property (@(posedge clk) disable iff (force_on)
    (!rst_n && $past(!rst_n) && !$past(force_on)) |-> (q_r == RST_VAL));

  p_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |-> (q_r == ~RST_VAL));

  p_hold_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(force_on) && $past(rst_n)) |-> (q_r == ~RST_VAL));

endmodule

// File: rtl/pg_corrupt_bank.sv
module pg_corrupt_bank #(
  parameter int unsigned      WIDTH    = 16,
  parameter int unsigned      PCT      = 25,
  parameter logic [31:0]      SEED     = 32'h1234_5678,
  parameter logic [WIDTH-1:0] FUNC_SET = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgen,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] corrupt_mask
);

  logic [WIDTH-1:0] mask_w;

  pgc_select #(
    .WIDTH (WIDTH),
    .PCT   (PCT),
    .SEED  (SEED)
  ) u_select (
    .mask (mask_w)
  );

  for (genvar gi = 0; gi < int'(WIDTH); gi++) begin : g_bit
    pgc_cell #(
      .RST_VAL (FUNC_SET[gi])
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pgen  (pgen),
      .sel   (mask_w[gi]),
      .d     (d[gi]),
      .q     (q[gi])
    );
  end

  assign corrupt_mask = mask_w;

  p_unselected_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(d)) & ~mask_w) == '0));

endmodule

// File: tb/pg_corrupt_bank_test.sv
module pg_corrupt_bank_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          W1  = 16;
  localparam logic [15:0] FS1 = 16'hA5C3;
  localparam int          W2  = 8;
  localparam logic [7:0]  FS2 = 8'h3C;

  logic          clk;
  logic          rst_n;
  logic          pgen;
  logic [W1-1:0] d;
  logic [W1-1:0] q1;
  logic [W1-1:0] mask1;
  logic [W2-1:0] q2;
  logic [W2-1:0] mask2;

  logic [W1-1:0] m1;
  logic [W2-1:0] m2;

  int vectors;
  int misses;
  bit done;

  pg_corrupt_bank #(.WIDTH(W1), .PCT(25), .SEED(32'h1234_5678), .FUNC_SET(FS1)) uut (
    .clk(clk), .rst_n(rst_n), .pgen(pgen), .d(d), .q(q1), .corrupt_mask(mask1));

  pg_corrupt_bank #(.WIDTH(W2), .PCT(100), .SEED(32'h0BAD_F00D), .FUNC_SET(FS2)) uut_all (
    .clk(clk), .rst_n(rst_n), .pgen(pgen), .d(d[W2-1:0]), .q(q2), .corrupt_mask(mask2));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(input string tag);
    vectors++;
    if (q1 !== m1) begin
      misses++;
      $display("FAIL %s wide bank: q=%h expected=%h", tag, q1, m1);
    end
    vectors++;
    if (q2 !== m2) begin
      misses++;
      $display("FAIL %s full bank: q=%h expected=%h", tag, q2, m2);
    end
  endtask

  // Asynchronous effects: gating forces selected bits, reset sets the rest.
  task automatic model_async();
    logic [W1-1:0] f1;
    logic [W2-1:0] f2;
    f1 = mask1 & {W1{pgen}};
    f2 = mask2 & {W2{pgen}};
    m1 = (m1 & ~f1) | (~FS1 & f1);
    m2 = (m2 & ~f2) | (~FS2 & f2);
    if (!rst_n) begin
      m1 = (m1 & f1) | (FS1 & ~f1);
      m2 = (m2 & f2) | (FS2 & ~f2);
    end
  endtask

  task automatic model_clock();
    logic [W1-1:0] e1;
    logic [W2-1:0] e2;
    e1 = ~(mask1 & {W1{pgen}});
    e2 = ~(mask2 & {W2{pgen}});
    if (rst_n) begin
      m1 = (m1 & ~e1) | (d & e1);
      m2 = (m2 & ~e2) | (d[W2-1:0] & e2);
    end
  endtask

  task automatic step(input logic npg, input logic nrn, input string tag_a, input string tag_c);
    @(negedge clk);
    d     = W1'($urandom);
    pgen  = npg;
    rst_n = nrn;
    #1;
    model_async();
    compare(tag_a);
    @(posedge clk);
    #1;
    model_clock();
    compare(tag_c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    $display("FAIL watchdog: run did not end, elapsed=%0t expected=below limit", $time);
    finish_run();
  end

  initial begin
    vectors = 0;
    misses  = 0;
    done    = 1'b0;
    rst_n   = 1'b1;
    pgen    = 1'b0;
    d       = '0;
    #1;
    rst_n = 1'b0;
    #1;
    m1 = FS1;
    m2 = FS2;
    compare("R1");

    vectors++;
    if ($countones(mask1) != 4) begin
      misses++;
      $display("FAIL R7 mask count: got=%0d expected=4", $countones(mask1));
    end
    vectors++;
    if (mask2 !== 8'hFF) begin
      misses++;
      $display("FAIL R9 full mask: got=%h expected=ff", mask2);
    end

    step(1'b0, 1'b0, "R1", "R1");
    step(1'b0, 1'b0, "R1", "R1");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R5", "R5");

    step(1'b1, 1'b1, "R2", "R4");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R4", "R4");
    step(1'b0, 1'b1, "R6", "R5");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R5", "R5");

    step(1'b1, 1'b1, "R2", "R4");
    step(1'b1, 1'b0, "R3", "R3");
    step(1'b1, 1'b0, "R3", "R3");
    step(1'b1, 1'b1, "R8", "R8");
    step(1'b0, 1'b1, "R8", "R5");
    step(1'b0, 1'b0, "R1", "R1");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R5", "R5");

    for (int r = 0; r < 8; r++) begin
      int on_len;
      on_len = 1 + int'($urandom % 4);
      step(1'b1, 1'b1, "R2", "R4");
      for (int k = 0; k < on_len; k++) step(1'b1, 1'b1, "R4", "R4");
      step(1'b0, 1'b1, "R6", "R5");
      for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R5", "R5");
    end

    finish_run();
  end

endmodule